// File: doc/BRIEF.md
# Tagged multi-source capture queue

This block merges samples from twelve producers into one shared queue of 16-bit entries: six serial sensor byte streams, two encoder counter snapshots, a snapshot of the four external input pins, a snapshot of the six receive-line levels, and two ADC samples. Each entry pairs one data byte with a tag byte, so a reader can tell which producer an entry came from. It can also tell which byte of a wider sample the entry holds.

Producers offer a word with a valid level and hold it until their acknowledge is seen. A fixed-priority arbiter picks one eligible producer at a time. A serializer then turns its word into one entry per clock, starting with the least significant byte. The host sees a fill level, a read port, a one-shot clear and two threshold flags for its interrupt logic. When the reader falls behind, the queue keeps the newest entries and discards the oldest.

Every source has its own enable bit. In addition, each external input pin can block a group of sources while that pin is high, unless that pin's override bit is set.

Top module: `tagq_top`

## Requirements
- R1: Each entry is laid out as follows. Bits 7:0 hold the data byte and bits 10:8 the byte index. Bits 13:11 hold the channel and bits 15:14 the source class. The class codes are 00 sensor, 01 encoder, 10 switching inputs and 11 ADC. Sensor channels are 0..5, encoder channels 0..1 and ADC channels 0..1.
- R2: A multi-byte sample is stored as consecutive entries with byte index 0, 1, 2 and so on, least significant byte first. An encoder snapshot has ENC_BYTES bytes and an ADC sample has ADC_BYTES bytes. Every other source has one byte.
- R3: The external-pin snapshot is stored as class 10, channel 0, with the pins in bits 3:0. The receive-line snapshot is stored as class 10, channel 1, with the lines in bits 5:0.
- R4: The source index order 0..11 is sensors 1-6, encoders 1-2, pin snapshot, receive-line snapshot, ADC 1-2. Among simultaneously valid eligible sources, the lowest index is served first. A source that is not served keeps its data until its acknowledge.
- R5: `src_en[i]` enables source i, using the index order of R4. A disabled source's offer is acknowledged and discarded, and no entry is stored.
- R6: While `ext_in[k]` is 1 and `gate_off[k]` is 0, a group of sources is blocked and handled as if disabled. Pin 0 blocks sensors 1-2. Pin 1 blocks sensors 3-6. Pin 2 blocks both encoders. Pin 3 blocks the ADCs and both snapshot sources. Setting `gate_off[k]` to 1 removes the effect of pin k.
- R7: `fill` reports the entry count in bits 14:0, capped at 32767, and bit 15 always reads 0. `rd_data` presents the oldest entry one cycle after `rd_en`. A read of an empty queue changes neither `rd_data` nor `fill`.
- R8: When the queue holds DEPTH entries, a new entry discards the oldest one, so the newest DEPTH entries are kept and `fill` stays at DEPTH.
- R9: A one-cycle pulse on `clr` empties the queue by the next cycle, and an entry arriving in the same cycle is discarded.
- R10: `half_flag` is 1 exactly when fill > DEPTH/2. `tq_flag` is 1 exactly when fill > 3·DEPTH/4. Both flags change in the same cycle as `fill`.
- R11: After reset the queue is empty, `fill`, `rd_data` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 12 | Per-source enable, index order of R4 |
| gate_off | input | 4 | Per-pin override of the pin gating |
| sens_vld | input | 6 | Sensor byte valid |
| sens_byte | input | 48 | Sensor bytes, channel n in bits 8n+7:8n |
| sens_ack | output | 6 | Sensor byte taken or discarded |
| enc_vld | input | 2 | Encoder snapshot valid |
| enc_cnt | input | 2·8·ENC_BYTES | Encoder snapshots |
| enc_ack | output | 2 | Encoder snapshot taken or discarded |
| ext_in | input | 4 | External pin levels (gating and snapshot data) |
| ext_snap | input | 1 | Request a pin snapshot |
| ext_ack | output | 1 | Pin snapshot taken or discarded |
| rxd_lines | input | 6 | Receive-line levels |
| rxd_snap | input | 1 | Request a receive-line snapshot |
| rxd_ack | output | 1 | Receive-line snapshot taken or discarded |
| adc_vld | input | 2 | ADC sample valid |
| adc_smp | input | 2·8·ADC_BYTES | ADC samples |
| adc_ack | output | 2 | ADC sample taken or discarded |
| clr | input | 1 | One-shot queue clear |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 16 | Popped entry |
| fill | output | 16 | Entry count |
| half_flag | output | 1 | Fill above one half of the depth |
| tq_flag | output | 1 | Fill above three quarters of the depth |

## Verification
The bench builds the block with ADDR_W=5 (32 entries), ENC_BYTES=4 and ADC_BYTES=2. With these values every fill level, both flag thresholds and the overwrite of the oldest entry can be stepped through one entry at a time. The bench sweeps all sixteen pin patterns against the gating and every single disabled source. It compares the resulting counts with a count formula computed from the group map. With all twelve sources requesting at once, it checks the full service order entry by entry.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
  localparam int NSRC  = 12;
  localparam int SRC_W = 4;

  typedef enum logic [1:0] {
    CLS_SENS = 2'b00,
    CLS_ENC  = 2'b01,
    CLS_SW   = 2'b10,
    CLS_ADC  = 2'b11
  } src_class_e;

  // upper five tag bits for a source index: class then channel
  function automatic logic [4:0] class_chan(input logic [SRC_W-1:0] s);
    logic [4:0] r;
    if (s < 4'd6)       r = {CLS_SENS, s[2:0]};
    else if (s < 4'd8)  r = {CLS_ENC, 3'(s - 4'd6)};
    else if (s == 4'd8) r = {CLS_SW, 3'd0};
    else if (s == 4'd9) r = {CLS_SW, 3'd1};
    else                r = {CLS_ADC, 3'(s - 4'd10)};
    return r;
  endfunction

  // gating pin that controls a source index
  function automatic int gate_group(input int s);
    if (s < 2) return 0;
    if (s < 6) return 1;
    if (s < 8) return 2;
    return 3;
  endfunction
endpackage

// File: rtl/tagq_arb.sv
module tagq_arb #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  allow,
  input  logic          can_take,
  output logic [N-1:0]  grant,
  output logic [N-1:0]  ack,
  output logic [IW-1:0] gidx,
  output logic          gvalid
);
  always_comb begin
    grant  = '0;
    gidx   = '0;
    gvalid = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (can_take && !gvalid && req[i] && allow[i]) begin
        grant[i] = 1'b1;
        gidx     = IW'(i);
        gvalid   = 1'b1;
      end
    end
  end

  // blocked offers are consumed at once so producers never stall on them
  assign ack = grant | (req & ~allow);

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R5
  blocked_not_granted_chk: assert property (@(posedge clk) disable iff (rst)
    (req & ~allow) != '0 |-> (grant & ~allow) == '0);
endmodule

// File: rtl/tagq_ser.sv
module tagq_ser
  import tagq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ENC_BYTES = 4,
  parameter int ADC_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [SRC_W-1:0]  sel_src,
  input  logic [WORD_W-1:0] sel_word,
  output logic              can_take,
  output logic              push,
  output logic [15:0]       entry
);
  localparam logic [2:0] ENC_LAST = 3'(ENC_BYTES - 1);
  localparam logic [2:0] ADC_LAST = 3'(ADC_BYTES - 1);

  logic              busy;
  logic [SRC_W-1:0]  src;
  logic [2:0]        idx;
  logic [2:0]        last;
  logic [WORD_W-1:0] word;

  function automatic logic [2:0] last_of(input logic [SRC_W-1:0] s);
    if (s == 4'd6 || s == 4'd7)   return ENC_LAST;
    if (s == 4'd10 || s == 4'd11) return ADC_LAST;
    return 3'd0;
  endfunction

  assign can_take = !busy || (idx == last);
  assign push     = busy;
  assign entry    = {class_chan(src), idx, word[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      src  <= '0;
      idx  <= '0;
      last <= '0;
      word <= '0;
    end else if (take) begin
      busy <= 1'b1;
      src  <= sel_src;
      idx  <= 3'd0;
      last <= last_of(sel_src);
      word <= sel_word;
    end else if (busy) begin
      if (idx == last) begin
        busy <= 1'b0;
      end else begin
        idx  <= idx + 3'd1;
        word <= word >> 8;
      end
    end
  end

  // R2
  byte_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy && (idx != last) |=> busy && (idx == 3'($past(idx) + 3'd1)) && $stable(src));
endmodule

// File: rtl/tagq_ring.sv
module tagq_ring #(
  parameter int ADDR_W = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic [15:0] din,
  input  logic        pop,
  input  logic        clr,
  output logic [15:0] dout,
  output logic [15:0] fill,
  output logic        half_flag,
  output logic        tq_flag
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TQ_CNT   = CW'((3 * DEPTH) / 4);

  logic [15:0]       mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rptr;
  logic [CW-1:0]     cnt, cnt_nxt;
  logic              do_push, do_pop, drop_old;

  assign do_push  = push && !clr;
  assign do_pop   = pop && (cnt != '0) && !clr;
  assign drop_old = do_push && (cnt == FULL_CNT) && !do_pop;

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt + CW'(do_push) - CW'(do_pop) - CW'(drop_old);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (do_pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push)            wptr <= wptr + 1'b1;
      if (do_pop || drop_old) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      fill      <= '0;
      half_flag <= 1'b0;
      tq_flag   <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      half_flag <= cnt_nxt > HALF_CNT;
      tq_flag   <= cnt_nxt > TQ_CNT;
      if (int'(cnt_nxt) > 32767) fill <= 16'h7fff;
      else                       fill <= 16'(cnt_nxt);
    end
  end

  // R8
  keep_newest_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL_CNT) && do_push && !do_pop |=> cnt == FULL_CNT);

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fill == 16'd0) && !half_flag && !tq_flag);

  // R10
  flag_order_chk: assert property (@(posedge clk) disable iff (rst)
    tq_flag |-> half_flag);

  // R7
  fill_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
    fill[15] == 1'b0);
endmodule

// File: rtl/tagq_top.sv
module tagq_top
  import tagq_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ENC_BYTES = 4,
  parameter int ADC_BYTES = 2,
  parameter int ENC_W     = 8 * ENC_BYTES,
  parameter int ADC_W     = 8 * ADC_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [11:0]        src_en,
  input  logic [3:0]         gate_off,
  input  logic [5:0]         sens_vld,
  input  logic [47:0]        sens_byte,
  output logic [5:0]         sens_ack,
  input  logic [1:0]         enc_vld,
  input  logic [2*ENC_W-1:0] enc_cnt,
  output logic [1:0]         enc_ack,
  input  logic [3:0]         ext_in,
  input  logic               ext_snap,
  output logic               ext_ack,
  input  logic [5:0]         rxd_lines,
  input  logic               rxd_snap,
  output logic               rxd_ack,
  input  logic [1:0]         adc_vld,
  input  logic [2*ADC_W-1:0] adc_smp,
  output logic [1:0]         adc_ack,
  input  logic               clr,
  input  logic               rd_en,
  output logic [15:0]        rd_data,
  output logic [15:0]        fill,
  output logic               half_flag,
  output logic               tq_flag
);
  localparam int MAXB   = (ENC_BYTES > ADC_BYTES) ? ENC_BYTES : ADC_BYTES;
  localparam int WORD_W = 8 * MAXB;

  logic [NSRC-1:0]   req, allow, grant, ack;
  logic [3:0]        blk;
  logic [WORD_W-1:0] words [NSRC];
  logic [WORD_W-1:0] sel_word;
  logic [SRC_W-1:0]  gidx;
  logic              gvalid, can_take, push;
  logic [15:0]       entry;

  assign req = {adc_vld, rxd_snap, ext_snap, enc_vld, sens_vld};
  assign blk = ext_in & ~gate_off;

  for (genvar s = 0; s < 6; s++) begin : g_sens
    assign words[s] = WORD_W'(sens_byte[8*s +: 8]);
  end
  for (genvar e = 0; e < 2; e++) begin : g_enc
    assign words[6+e]  = WORD_W'(enc_cnt[ENC_W*e +: ENC_W]);
    assign words[10+e] = WORD_W'(adc_smp[ADC_W*e +: ADC_W]);
  end
  assign words[8] = WORD_W'(ext_in);
  assign words[9] = WORD_W'(rxd_lines);

  for (genvar i = 0; i < NSRC; i++) begin : g_allow
    localparam int G = gate_group(i);
    assign allow[i] = src_en[i] && !blk[G];
  end

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) sel_word = words[i];
    end
  end

  assign {adc_ack, rxd_ack, ext_ack, enc_ack, sens_ack} = ack;

  tagq_arb #(.N(NSRC), .IW(SRC_W)) i_arb (
    .clk(clk), .rst(rst), .req(req), .allow(allow), .can_take(can_take),
    .grant(grant), .ack(ack), .gidx(gidx), .gvalid(gvalid)
  );

  tagq_ser #(.WORD_W(WORD_W), .ENC_BYTES(ENC_BYTES), .ADC_BYTES(ADC_BYTES)) i_ser (
    .clk(clk), .rst(rst), .take(gvalid), .sel_src(gidx), .sel_word(sel_word),
    .can_take(can_take), .push(push), .entry(entry)
  );

  tagq_ring #(.ADDR_W(ADDR_W)) i_ring (
    .clk(clk), .rst(rst), .push(push), .din(entry), .pop(rd_en), .clr(clr),
    .dout(rd_data), .fill(fill), .half_flag(half_flag), .tq_flag(tq_flag)
  );

  // R6
  pin_block_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_in[0] && !gate_off[0]) |-> (grant[1:0] == 2'b00));
endmodule

// File: tb/test_tagq_top.sv
module test_tagq_top;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] src_en = 12'hfff;
  logic [3:0]  gate_off = 4'hf;
  logic [5:0]  sens_vld = '0;
  logic [47:0] sens_byte = '0;
  logic [5:0]  sens_ack;
  logic [1:0]  enc_vld = '0;
  logic [63:0] enc_cnt = '0;
  logic [1:0]  enc_ack;
  logic [3:0]  ext_in = '0;
  logic        ext_snap = 1'b0;
  logic        ext_ack;
  logic [5:0]  rxd_lines = '0;
  logic        rxd_snap = 1'b0;
  logic        rxd_ack;
  logic [1:0]  adc_vld = '0;
  logic [31:0] adc_smp = '0;
  logic [1:0]  adc_ack;
  logic        clr = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data, fill;
  logic        half_flag, tq_flag;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tagq_top #(.ADDR_W(AW), .ENC_BYTES(4), .ADC_BYTES(2)) i_tagq_top (
    .clk(clk), .rst(rst), .src_en(src_en), .gate_off(gate_off),
    .sens_vld(sens_vld), .sens_byte(sens_byte), .sens_ack(sens_ack),
    .enc_vld(enc_vld), .enc_cnt(enc_cnt), .enc_ack(enc_ack),
    .ext_in(ext_in), .ext_snap(ext_snap), .ext_ack(ext_ack),
    .rxd_lines(rxd_lines), .rxd_snap(rxd_snap), .rxd_ack(rxd_ack),
    .adc_vld(adc_vld), .adc_smp(adc_smp), .adc_ack(adc_ack),
    .clr(clr), .rd_en(rd_en), .rd_data(rd_data), .fill(fill),
    .half_flag(half_flag), .tq_flag(tq_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nb(input int i);
    if (i == 6 || i == 7) return 4;
    if (i >= 10) return 2;
    return 1;
  endfunction

  function automatic int grp(input int i);
    if (i < 2) return 0;
    if (i < 6) return 1;
    if (i < 8) return 2;
    return 3;
  endfunction

  function automatic int exp_count(input logic [11:0] en, input logic [3:0] pins, input logic [3:0] goff);
    int n = 0;
    for (int i = 0; i < 12; i++)
      if (en[i] && !(pins[grp(i)] && !goff[grp(i)])) n += nb(i);
    return n;
  endfunction

  function automatic logic [15:0] ent(input logic [1:0] c, input int ch, input int ix, input logic [7:0] b);
    return {c, 3'(ch), 3'(ix), b};
  endfunction

  // offer the sources in mask m and hold each until acknowledged, then let the queue drain
  task automatic serve(input logic [11:0] m);
    logic [11:0] pend, a;
    int guard = 0;
    @(negedge clk);
    pend = m;
    while (pend != '0 && guard < 100) begin
      {adc_vld, rxd_snap, ext_snap, enc_vld, sens_vld} = pend;
      #1;
      a = {adc_ack, rxd_ack, ext_ack, enc_ack, sens_ack} & pend;
      @(negedge clk);
      pend = pend & ~a;
      guard++;
    end
    {adc_vld, rxd_snap, ext_snap, enc_vld, sens_vld} = '0;
    repeat (10) @(negedge clk);
  endtask

  task automatic pop(output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] expq [20];
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 fill", 32'(fill), 0);
    chk("R11 rd_data", 32'(rd_data), 0);
    chk("R11 flags", {30'd0, half_flag, tq_flag}, 0);

    // R1 each sensor channel tagged
    for (int s = 0; s < 6; s++) begin
      sens_byte[8*s +: 8] = 8'(8'ha0 + s);
      serve(12'(1 << s));
      pop(v);
      chk("R1 sensor entry", 32'(v), 32'(ent(2'b00, s, 0, 8'(8'ha0 + s))));
    end

    // R2 multi-byte split, lsb first
    enc_cnt = {32'hcafe_f00d, 32'h1234_5678};
    adc_smp = {16'hbee1, 16'hbee0};
    for (int e = 0; e < 2; e++) begin
      serve(12'(1 << (6 + e)));
      for (int b = 0; b < 4; b++) begin
        pop(v);
        chk("R2 encoder byte", 32'(v), 32'(ent(2'b01, e, b, enc_cnt[32*e + 8*b +: 8])));
      end
      serve(12'(1 << (10 + e)));
      for (int b = 0; b < 2; b++) begin
        pop(v);
        chk("R2 adc byte", 32'(v), 32'(ent(2'b11, e, b, adc_smp[16*e + 8*b +: 8])));
      end
    end

    // R3 switching-input snapshots
    ext_in = 4'b1010;
    rxd_lines = 6'h2d;
    serve(12'h100);
    pop(v);
    chk("R3 pin snapshot", 32'(v), 32'(ent(2'b10, 0, 0, 8'h0a)));
    serve(12'h200);
    pop(v);
    chk("R3 rxd snapshot", 32'(v), 32'(ent(2'b10, 1, 0, 8'h2d)));
    chk("R7 empty after reads", 32'(fill), 0);

    // R4 all sources at once: fixed order
    n = 0;
    for (int s = 0; s < 6; s++) expq[n++] = ent(2'b00, s, 0, 8'(8'ha0 + s));
    for (int e = 0; e < 2; e++)
      for (int b = 0; b < 4; b++) expq[n++] = ent(2'b01, e, b, enc_cnt[32*e + 8*b +: 8]);
    expq[n++] = ent(2'b10, 0, 0, 8'h0a);
    expq[n++] = ent(2'b10, 1, 0, 8'h2d);
    for (int e = 0; e < 2; e++)
      for (int b = 0; b < 2; b++) expq[n++] = ent(2'b11, e, b, adc_smp[16*e + 8*b +: 8]);
    serve(12'hfff);
    chk("R4 fill after burst", 32'(fill), 20);
    for (int k = 0; k < 20; k++) begin
      pop(v);
      chk("R4 service order", 32'(v), 32'(expq[k]));
    end

    // R5 each single source disabled
    for (int i = 0; i < 12; i++) begin
      src_en = 12'hfff & ~12'(1 << i);
      serve(12'hfff);
      chk("R5 disabled source dropped", 32'(fill), 32'(exp_count(src_en, ext_in, gate_off)));
      do_clear();
      chk("R9 clear empties", 32'(fill), 0);
    end
    src_en = 12'hfff;

    // R6 pin gating sweep
    gate_off = 4'h0;
    for (int p = 0; p < 16; p++) begin
      ext_in = 4'(p);
      serve(12'hfff);
      chk("R6 gated count", 32'(fill), 32'(exp_count(12'hfff, ext_in, gate_off)));
      do_clear();
    end
    ext_in = 4'hf;
    for (int k = 0; k < 4; k++) begin
      gate_off = 4'(1 << k);
      serve(12'hfff);
      chk("R6 override bit", 32'(fill), 32'(exp_count(12'hfff, ext_in, gate_off)));
      do_clear();
    end
    gate_off = 4'hf;
    ext_in = 4'h0;

    // R10 / R7 / R8 fill ramp then overwrite
    for (int k = 1; k <= 40; k++) begin
      sens_byte[7:0] = 8'(k);
      serve(12'h001);
      chk("R7 fill level", 32'(fill), 32'((k > DEPTH) ? DEPTH : k));
      chk("R10 half flag", 32'(half_flag), 32'(((k > DEPTH) ? DEPTH : k) > DEPTH / 2));
      chk("R10 three-quarter flag", 32'(tq_flag), 32'(((k > DEPTH) ? DEPTH : k) > (3 * DEPTH) / 4));
    end
    for (int k = 0; k < DEPTH; k++) begin
      pop(v);
      chk("R8 newest kept", 32'(v), 32'(ent(2'b00, 0, 0, 8'(9 + k))));
    end

    // R7 read of empty queue ignored
    pop(v);
    chk("R7 empty read data", 32'(rd_data), 32'(ent(2'b00, 0, 0, 8'd40)));
    chk("R7 empty read fill", 32'(fill), 0);

    // R9 clear with entries present
    serve(12'h0c0);
    chk("R9 before clear", 32'(fill), 8);
    do_clear();
    chk("R9 after clear", {15'd0, fill, half_flag}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule